// File: doc/BRIEF.md
# Slipping Elastic Bit Buffer

This block is a serial bit buffer that carries a single bit stream from a write clock domain, timed by the attached terminal equipment, into a read clock domain, timed by the modem's own oscillator. It absorbs short-term jitter, slow drift between two free-running clocks and the cyclic delay variation of a satellite hop. The same block serves the send-data direction and the receive-data direction. A bit is stored on each write-clock cycle with `wr_en` high, and a bit is delivered on each read-clock cycle with `rd_en` high. The write pointer crosses into the read domain as a Gray code through a two-flop synchronizer.

After reset the read side drives idle ones. It starts to deliver stored bits once the buffer is half full. If the two rates differ long enough for the fill seen by the read side to reach an upper or lower limit, the buffer neither stalls nor drops single bits. It moves its read pointer by one whole frame: forward to discard a frame when too full, backward to repeat a frame when too empty. This brings the fill back toward the centre. It flags the event with a one-cycle pulse and a direction bit and increments a saturating event counter.

Top module: `elastic_slip_buffer`

## Requirements
- R1: While `rd_rst` is high, and on the first read-clock cycle after it, `rd_bit` is 1, `rd_live` is 0, `slip_pulse` is 0 and `slip_count` is 0.
- R2: While `rd_live` is 0, `rd_bit` is 1. `rd_live` rises only after at least DEPTH/2 (32) bits have been written, and it never falls again until reset.
- R3: While `rd_live` is 1, each read-clock edge with `rd_en` high puts the next stored bit, in write order and with no gaps, on `rd_bit` after that edge. `rd_bit` holds its value when `rd_en` is low.
- R4: When the read and write rates match, the fill stays between the limits and no slip occurs.
- R5: When the synchronized fill reaches HI_MARK (60), the read position jumps forward by exactly FRAME (24) bits, so that one frame is discarded. `slip_dir` becomes 1.
- R6: When the synchronized fill falls to LO_MARK (4), the read position moves back by exactly FRAME bits, so that one frame is delivered again. `slip_dir` becomes 0.
- R7: Each slip gives a `slip_pulse` that lasts one read-clock cycle. Two pulses never occur on consecutive cycles, a pulse occurs only while `rd_live` is 1, and `slip_dir` changes only together with a pulse.
- R8: `slip_count` increments by one on each slip and stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock (terminal equipment timing) |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Store `wr_bit` on this write-clock edge |
| wr_bit | input | 1 | Serial data bit in |
| rd_clk | input | 1 | Read-domain clock (internal timing) |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Take one bit on this read-clock edge |
| rd_bit | output | 1 | Serial data bit out, registered |
| rd_live | output | 1 | High once stored data is being delivered |
| slip_pulse | output | 1 | One-cycle flag for a frame slip |
| slip_dir | output | 1 | Direction of the last slip: 1 = frame discarded, 0 = frame repeated |
| slip_count | output | CNT_W | Saturating number of slips since reset |

## Verification
The hardest condition to reach from the ports is a slip in each direction, with the exact frame displacement visible in the data. It occurs only after the rates have diverged long enough, and its effect shows up as a jump in an otherwise continuous bit sequence. The bench drives both clocks at the same period with a phase offset and paces each side with its enable. It first balances the rates, then halves the read rate to drive the buffer to overfill, then halves the write rate to drive it to underfill. Throughout, a model that holds every written bit predicts each delivered bit and shifts its expected index by one frame at each reported slip, so a wrong step size or direction shows up as data mismatches.

// File: rtl/esb_pkg.sv
package esb_pkg;
  // direction reported with a slip
  typedef enum logic {
    SLIP_REPEAT = 1'b0,  // fill too low: one frame is sent again
    SLIP_DROP   = 1'b1   // fill too high: one frame is skipped
  } slip_dir_e;
endpackage

// File: rtl/esb_wr_ptr.sv
module esb_wr_ptr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] ptr_bin,
  output logic [AW-1:0] ptr_gray
);
  logic [AW-1:0] nxt;

  assign nxt = ptr_bin + {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_bin  <= '0;
      ptr_gray <= '0;
    end else if (en) begin
      ptr_bin  <= nxt;
      ptr_gray <= nxt ^ (nxt >> 1);
    end
  end
endmodule

// File: rtl/esb_sync2.sv
module esb_sync2 #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/esb_bitram.sv
module esb_bitram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_q
);
  logic store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) store[wr_addr] <= wr_bit;
  end

  // registered read port, reset to the idle level
  always_ff @(posedge rd_clk) begin
    if (rd_rst)     rd_q <= 1'b1;
    else if (rd_en) rd_q <= store[rd_addr];
  end
endmodule

// File: rtl/esb_rd_ctrl.sv
module esb_rd_ctrl
  import esb_pkg::*;
#(
  parameter int AW      = 6,
  parameter int FRAME   = 24,
  parameter int HI_MARK = 60,
  parameter int LO_MARK = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [AW-1:0]    wgray_s,
  output logic [AW-1:0]    rptr,
  output logic             ram_en,
  output logic             live,
  output logic             slip_pulse,
  output logic             slip_dir,
  output logic [CNT_W-1:0] slip_count
);
  localparam int            CENTER  = (1 << AW) / 2;
  localparam logic [AW-1:0] FRAME_V = AW'(FRAME);
  localparam logic [AW-1:0] HI_V    = AW'(HI_MARK);
  localparam logic [AW-1:0] LO_V    = AW'(LO_MARK);
  localparam logic [AW-1:0] CTR_V   = AW'(CENTER);

  logic [AW-1:0] wbin, fill, rptr_nx;
  logic          go_drop, go_repeat, adv;
  slip_dir_e     dir_nx;

  always_comb begin
    for (int i = 0; i < AW; i++) wbin[i] = ^(wgray_s >> i);
  end

  assign fill      = wbin - rptr;
  assign go_drop   = live && (fill >= HI_V);
  assign go_repeat = live && (fill <= LO_V);
  assign adv       = live && rd_en;
  assign ram_en    = adv;
  assign dir_nx    = go_drop ? SLIP_DROP : SLIP_REPEAT;

  always_comb begin
    rptr_nx = rptr + {{(AW-1){1'b0}}, adv};
    if (go_drop)        rptr_nx = rptr_nx + FRAME_V;
    else if (go_repeat) rptr_nx = rptr_nx - FRAME_V;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr       <= '0;
      live       <= 1'b0;
      slip_pulse <= 1'b0;
      slip_dir   <= 1'b0;
      slip_count <= '0;
    end else begin
      rptr       <= rptr_nx;
      slip_pulse <= go_drop || go_repeat;
      if (go_drop || go_repeat) begin
        slip_dir <= dir_nx;
        if (slip_count != '1) slip_count <= slip_count + 1'b1;
      end
      if (!live && (fill >= CTR_V)) live <= 1'b1;
    end
  end
endmodule

// File: rtl/elastic_slip_buffer.sv
module elastic_slip_buffer #(
  parameter int DEPTH   = 64,
  parameter int FRAME   = 24,
  parameter int HI_MARK = 60,
  parameter int LO_MARK = 4,
  parameter int CNT_W   = 8
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  output logic             rd_bit,
  output logic             rd_live,
  output logic             slip_pulse,
  output logic             slip_dir,
  output logic [CNT_W-1:0] slip_count
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] wptr_bin, wptr_gray, wgray_s, rptr;
  logic          ram_en;

  esb_wr_ptr #(.AW(AW)) u_wptr (
    .clk      (wr_clk),
    .rst      (wr_rst),
    .en       (wr_en),
    .ptr_bin  (wptr_bin),
    .ptr_gray (wptr_gray)
  );

  esb_sync2 #(.W(AW)) u_wsync (
    .clk (rd_clk),
    .rst (rd_rst),
    .d   (wptr_gray),
    .q   (wgray_s)
  );

  esb_rd_ctrl #(
    .AW(AW), .FRAME(FRAME), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .CNT_W(CNT_W)
  ) u_rctl (
    .clk        (rd_clk),
    .rst        (rd_rst),
    .rd_en      (rd_en),
    .wgray_s    (wgray_s),
    .rptr       (rptr),
    .ram_en     (ram_en),
    .live       (rd_live),
    .slip_pulse (slip_pulse),
    .slip_dir   (slip_dir),
    .slip_count (slip_count)
  );

  esb_bitram #(.DEPTH(DEPTH)) u_ram (
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_addr (wptr_bin),
    .wr_bit  (wr_bit),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .rd_en   (ram_en),
    .rd_addr (rptr),
    .rd_q    (rd_bit)
  );
endmodule

// File: rtl/elastic_slip_buffer_chk.sv
module elastic_slip_buffer_chk #(
  parameter int CNT_W = 8
) (
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             rd_bit,
  input logic             rd_live,
  input logic             slip_pulse,
  input logic             slip_dir,
  input logic [CNT_W-1:0] slip_count
);
  assert_reset_state_R1: assert property (@(posedge rd_clk)
    rd_rst |=> (rd_bit && !rd_live && !slip_pulse && slip_count == '0));

  assert_idle_ones_R2: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_live |-> rd_bit);

  assert_live_sticky_R2: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !$fell(rd_live));

  assert_single_pulse_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    slip_pulse |=> !slip_pulse);

  assert_pulse_when_live_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    slip_pulse |-> rd_live);

  assert_dir_held_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !slip_pulse |-> $stable(slip_dir));

  assert_count_moves_on_pulse_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (slip_count != $past(slip_count)) |-> slip_pulse);

  assert_count_step_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (slip_pulse && $past(slip_count) != '1) |-> (slip_count == $past(slip_count) + 1'b1));
endmodule

bind elastic_slip_buffer elastic_slip_buffer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/elastic_slip_buffer_bench.sv
module elastic_slip_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 24;
  localparam int CENTER     = 32;
  localparam int CNT_W      = 3;
  localparam int CNT_MAX    = 7;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
  logic rd_bit, rd_live, slip_pulse, slip_dir;
  logic [CNT_W-1:0] slip_count;

  elastic_slip_buffer #(.FRAME(FRAME), .CNT_W(CNT_W)) u_elastic_slip_buffer (
    .wr_clk, .wr_rst, .wr_en, .wr_bit,
    .rd_clk, .rd_rst, .rd_en, .rd_bit, .rd_live,
    .slip_pulse, .slip_dir, .slip_count
  );

  initial forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #(CLK_PERIOD/2) rd_clk = ~rd_clk;
  end

  int n_chk = 0, n_fail = 0;
  int wr_pace = 0, rd_pace = 0;
  int wr_count = 0, exp_idx = 0, slips_seen = 0;
  int last_dir = -1;
  logic wr_hist [0:65535];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // write side driver: store a pseudo-random bit every wr_pace cycles
  initial begin
    int tick = 0;
    forever begin
      @(negedge wr_clk);
      tick++;
      if (!wr_rst && wr_pace != 0 && (tick % wr_pace) == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_bit = lfsr[0];
        wr_hist[wr_count[15:0]] = lfsr[0];
        wr_count++;
        wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
    end
  end

  // read side monitor and driver, away from the rising edge
  initial begin
    int tick = 0;
    logic prev_live = 1'b0, prev_pulse = 1'b0;
    forever begin
      @(negedge rd_clk);
      if (rd_rst) begin
        prev_live = 1'b0; prev_pulse = 1'b0; rd_en = 1'b0;
      end else begin
        if (!rd_live) check(rd_bit == 1'b1, "R2 idle ones", int'(rd_bit), 1);
        if (rd_live && !prev_live) check(wr_count >= CENTER, "R2 live start", wr_count, CENTER);
        if (!rd_live && prev_live) check(1'b0, "R2 live fell", 0, 1);
        if (prev_live && rd_en) begin
          check(rd_bit == wr_hist[exp_idx[15:0]], "R3/R5/R6 data order",
                int'(rd_bit), int'(wr_hist[exp_idx[15:0]]));
          exp_idx++;
        end
        if (slip_pulse) begin
          check(!prev_pulse, "R7 pulse width", 1, 0);
          slips_seen++;
          last_dir = int'(slip_dir);
          exp_idx = slip_dir ? exp_idx + FRAME : exp_idx - FRAME;
          check(int'(slip_count) == ((slips_seen > CNT_MAX) ? CNT_MAX : slips_seen),
                "R8 count", int'(slip_count), (slips_seen > CNT_MAX) ? CNT_MAX : slips_seen);
        end
        prev_live  = rd_live;
        prev_pulse = slip_pulse;
        tick++;
        rd_en = (rd_pace != 0 && (tick % rd_pace) == 0);
      end
    end
  end

  task automatic run_rd(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic test_reset;
    repeat (5) @(negedge wr_clk);
    check(rd_bit == 1'b1, "R1 rd_bit", int'(rd_bit), 1);
    check(rd_live == 1'b0, "R1 rd_live", int'(rd_live), 0);
    check(slip_pulse == 1'b0, "R1 slip_pulse", int'(slip_pulse), 0);
    check(slip_count == '0, "R1 slip_count", int'(slip_count), 0);
    wr_rst = 1'b0; rd_rst = 1'b0;
    run_rd(1);
    check(rd_bit == 1'b1 && !rd_live && slip_count == '0, "R1 after release",
          int'(rd_live), 0);
  endtask

  task automatic test_startup;
    int guard = 0;
    wr_pace = 1; rd_pace = 1;
    while (wr_count < 20) @(negedge wr_clk);
    wr_pace = 0;
    run_rd(30);
    check(rd_live == 1'b0, "R2 not live at 20 bits", int'(rd_live), 0);
    check(rd_bit == 1'b1, "R2 idle ones at 20 bits", int'(rd_bit), 1);
    rd_pace = 0;
    wr_pace = 1;
    while (!rd_live && guard < 200) begin run_rd(1); guard++; end
    rd_pace = 1;
    check(rd_live == 1'b1, "R2 live after centre", int'(rd_live), 1);
  endtask

  task automatic test_balanced;
    int s0 = slips_seen;
    int i0 = exp_idx;
    run_rd(600);
    check(slips_seen == s0, "R4 no slip at matched rates", slips_seen, s0);
    check(exp_idx - i0 > 550, "R3 bits delivered", exp_idx - i0, 600);
  endtask

  task automatic test_slip(input int wp, input int rp, input int want_dir, input int n,
                           input string req);
    int s0 = slips_seen;
    int guard = 0;
    wr_pace = wp; rd_pace = rp;
    while (slips_seen < s0 + n && guard < 3000) begin run_rd(1); guard++; end
    check(slips_seen >= s0 + n, req, slips_seen - s0, n);
    check(last_dir == want_dir, req, last_dir, want_dir);
  endtask

  task automatic test_saturate;
    test_slip(1, 2, 1, 4, "R8 more slips");
    check(slips_seen > CNT_MAX, "R8 beyond max", slips_seen, CNT_MAX + 1);
    check(int'(slip_count) == CNT_MAX, "R8 saturated", int'(slip_count), CNT_MAX);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    test_reset();
    test_startup();
    test_balanced();
    test_slip(1, 2, 1, 3, "R5 overfill drops frame");
    test_slip(2, 1, 0, 3, "R6 underfill repeats frame");
    test_saturate();
    wr_pace = 1; rd_pace = 1;
    run_rd(100);
    finish_run();
  end
endmodule